// File: doc/BRIEF.md
# Ring Roster Packet Processor

This block is the per-node engine of a flooding reconfiguration pass that rebuilds a logical ring after a fault. When a roster pass begins, the node clears its bookkeeping and emits one freshly built roster packet, which is sent on every transmitter at once. During the pass the node listens on up to four receive ports. Each roster packet that arrives has the node's own ID stamped into its last-transmitter field and its hop count incremented. The updated packet is then either forwarded or dropped, depending on a per-origin table that holds the highest hop count seen so far.

When the node's own packet comes back over a longer path than any earlier copy, the node selects the port it arrived on as its receive port. The wrap bit limits each packet to one pass over the point where the ring returns from its highest ID to its lowest. The node also reports whether it should act as the purge node, which is the case while no roster packet from a lower-ID origin has reached it.

Top module: `ring_roster_node`

## Requirements
- R1: After reset, tx_valid, rx_port_locked, purge_node, port_wrap and rx_accept are all zero.
- R2: A cycle with roster_start high produces, on the next cycle, tx_valid=1 with a packet that has wrap=0, last-transmitter=my_id, count=0 and origin=my_id. The same edge clears the max-count table, port_wrap and rx_port_locked, and sets purge_node to 1. Packet layout is bit 24 wrap, bits 23:16 last-transmitter, bits 15:8 count, bits 7:0 origin. Port p uses rx_pkt bits [p*25 +: 25].
- R3: A forwarded packet carries last-transmitter=my_id and count equal to the received count plus one, saturating at 255. It appears on tx two clock edges after the cycle in which it was accepted.
- R4: A packet whose origin equals my_id is never forwarded.
- R5: If the node's own packet arrives with an incremented count above the stored maximum for my_id, rx_port_sel takes the arrival port, rx_port_locked becomes 1, and the stored maximum is updated.
- R6: If a packet from another origin arrives with last-transmitter greater than my_id, one of two things happens. If its wrap bit is already 1, it is discarded. Otherwise it is forwarded (subject to R7) with wrap=1, and port_wrap of its arrival port is set.
- R7: A packet from another origin that is not dropped by R6 is forwarded only if its incremented count exceeds the stored maximum for that origin, and forwarding updates that maximum. Otherwise it is discarded.
- R8: purge_node drops to 0 once any roster packet with origin lower than my_id has been processed.
- R9: Packets valid on several ports are accepted one per cycle, lowest port number first. rx_accept is one-hot on the accepted port, and a port holds its packet until accepted.
- R10: While roster_start is high no packet is accepted, and a packet already in flight is dropped without being forwarded.
- R11: Two back-to-back packets from the same origin are judged against the table as already updated by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | 8 | This node's ID (1 to 254), static during a pass |
| roster_start | input | 1 | Begin a roster pass |
| rx_valid | input | 4 | Per-port packet present |
| rx_pkt | input | 100 | Per-port roster packet, 25 bits each |
| rx_accept | output | 4 | One-hot: port whose packet is taken this cycle |
| tx_valid | output | 1 | Packet on tx_pkt is to be sent on all transmitters |
| tx_pkt | output | 25 | Outgoing roster packet |
| rx_port_sel | output | 2 | Selected receive port |
| rx_port_locked | output | 1 | rx_port_sel has been chosen in this pass |
| port_wrap | output | 4 | Per-port flag: a wrap was marked on a packet from this port |
| purge_node | output | 1 | Node should purge orphan packets |

## Verification
Two events can land on the same edge: the table write made by one packet and the table read issued for the next packet from the same origin. This case is provoked by presenting two equal-origin packets on adjacent ports in the same cycle, so that the arbiter takes them back to back. The second packet must then be discarded because its count does not exceed the value the first one just stored. A second collision, a roster start arriving while a packet sits in the decision stage, is judged by seeing the freshly built packet on tx and no forwarded copy one cycle later.

// File: rtl/ring_roster_pkg.sv
package ring_roster_pkg;
  localparam int unsigned ID_W  = 8;
  localparam int unsigned CNT_W = 8;

  typedef struct packed {
    logic             wrap;
    logic [ID_W-1:0]  ltx;
    logic [CNT_W-1:0] count;
    logic [ID_W-1:0]  origin;
  } roster_pkt_t;

  localparam int unsigned PKT_W = $bits(roster_pkt_t);
endpackage

// File: rtl/rr_port_arbiter.sv
module rr_port_arbiter #(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [NPORTS-1:0] req,
  input  logic              en,
  output logic [NPORTS-1:0] gnt,
  output logic [SEL_W-1:0]  idx,
  output logic              any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (en && req[p]) begin
        gnt    = '0;
        gnt[p] = 1'b1;
        idx    = SEL_W'(p);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_maxcount_table.sv
module rr_maxcount_table #(
  parameter int unsigned ID_W  = 8,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned DEPTH = 1 << ID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             rd_en,
  input  logic [ID_W-1:0]  rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             we,
  input  logic [ID_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0] wr_data
);
  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] mem_q;
  logic [DEPTH-1:0] seen;
  logic             seen_q, hit_q;
  logic [CNT_W-1:0] byp_q;

  // Block-RAM style storage: no reset, registered read
  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
    if (rd_en) mem_q <= mem[rd_addr];
  end

  // Entry-written flags give a single-cycle clear of the whole table
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen   <= '0;
      seen_q <= 1'b0;
      hit_q  <= 1'b0;
      byp_q  <= '0;
    end else begin
      if (we) seen[wr_addr] <= 1'b1;
      if (rd_en) begin
        hit_q  <= we && (wr_addr == rd_addr);
        seen_q <= seen[rd_addr] || (we && (wr_addr == rd_addr));
        byp_q  <= wr_data;
      end
    end
  end

  assign rd_data = !seen_q ? '0 : (hit_q ? byp_q : mem_q);

  // R11
  bypass_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (we && rd_en && !clear && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data)));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !rd_en) |=> (rd_data == '0));
endmodule

// File: rtl/ring_roster_node.sv
module ring_roster_node
  import ring_roster_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ID_W-1:0]         my_id,
  input  logic                    roster_start,
  input  logic [NPORTS-1:0]       rx_valid,
  input  logic [NPORTS*PKT_W-1:0] rx_pkt,
  output logic [NPORTS-1:0]       rx_accept,
  output logic                    tx_valid,
  output logic [PKT_W-1:0]        tx_pkt,
  output logic [SEL_W-1:0]        rx_port_sel,
  output logic                    rx_port_locked,
  output logic [NPORTS-1:0]       port_wrap,
  output logic                    purge_node
);
  logic [SEL_W-1:0] g_idx;
  logic             g_any;
  roster_pkt_t      in_pkt;

  rr_port_arbiter #(.NPORTS(NPORTS)) arb_i (
    .req(rx_valid), .en(!roster_start), .gnt(rx_accept), .idx(g_idx), .any(g_any)
  );

  assign in_pkt = roster_pkt_t'(rx_pkt[g_idx*PKT_W +: PKT_W]);

  // Decision stage
  logic             s1_v;
  roster_pkt_t      s1_pkt;
  logic [SEL_W-1:0] s1_port;
  logic [CNT_W-1:0] tbl_max, cnt_inc;
  logic             own, wraps, drop_wrap, upd, fwd, sel_upd, mark_wrap;

  always_comb begin
    cnt_inc   = (s1_pkt.count == {CNT_W{1'b1}}) ? s1_pkt.count : s1_pkt.count + 1'b1;
    own       = (s1_pkt.origin == my_id);
    wraps     = (my_id < s1_pkt.ltx);
    drop_wrap = !own && wraps && s1_pkt.wrap;
    upd       = s1_v && !roster_start && !drop_wrap && (cnt_inc > tbl_max);
    fwd       = upd && !own;
    sel_upd   = upd && own;
    mark_wrap = s1_v && !own && wraps && !s1_pkt.wrap;
  end

  rr_maxcount_table #(.ID_W(ID_W), .CNT_W(CNT_W)) tbl_i (
    .clk(clk), .rst(rst), .clear(roster_start),
    .rd_en(g_any), .rd_addr(in_pkt.origin), .rd_data(tbl_max),
    .we(upd), .wr_addr(s1_pkt.origin), .wr_data(cnt_inc)
  );

  roster_pkt_t tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v           <= 1'b0;
      s1_pkt         <= '0;
      s1_port        <= '0;
      tx_valid       <= 1'b0;
      tx_q           <= '0;
      rx_port_sel    <= '0;
      rx_port_locked <= 1'b0;
      port_wrap      <= '0;
      purge_node     <= 1'b0;
    end else if (roster_start) begin
      s1_v           <= 1'b0;
      tx_valid       <= 1'b1;
      tx_q           <= '{wrap: 1'b0, ltx: my_id, count: '0, origin: my_id};
      rx_port_locked <= 1'b0;
      port_wrap      <= '0;
      purge_node     <= 1'b1;
    end else begin
      s1_v <= g_any;
      if (g_any) begin
        s1_pkt  <= in_pkt;
        s1_port <= g_idx;
      end
      tx_valid <= fwd;
      if (fwd) tx_q <= '{wrap: s1_pkt.wrap | wraps, ltx: my_id, count: cnt_inc, origin: s1_pkt.origin};
      if (sel_upd) begin
        rx_port_sel    <= s1_port;
        rx_port_locked <= 1'b1;
      end
      if (mark_wrap) port_wrap[s1_port] <= 1'b1;
      if (s1_v && (s1_pkt.origin < my_id)) purge_node <= 1'b0;
    end
  end

  assign tx_pkt = tx_q;

  // R2
  start_emit_chk: assert property (@(posedge clk) disable iff (rst)
    roster_start |=> (tx_valid && !tx_q.wrap && tx_q.count == '0 && tx_q.origin == my_id && purge_node));

  // R3
  fwd_ltx_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_q.ltx == my_id));

  // R4
  own_never_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !roster_start && s1_pkt.origin == my_id) |=> !tx_valid);

  // R9
  accept_order_chk: assert property (@(posedge clk) disable iff (rst)
    (|rx_accept) |-> (((rx_accept & rx_valid) == rx_accept) && (((rx_accept - 1'b1) & rx_valid) == '0)));

  // R10
  start_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    roster_start |-> (rx_accept == '0));
endmodule

// File: tb/ring_roster_node_tb_top.sv
`timescale 1ns/1ps
module ring_roster_node_tb_top;
  localparam int NP = 4;
  localparam int PW = 25;
  localparam int ID = 5;

  logic clk = 1'b0, rst = 1'b1, roster_start = 1'b0;
  logic [7:0] my_id = 8'(ID);
  logic [NP-1:0] rx_valid = '0, rx_accept, port_wrap;
  logic [NP*PW-1:0] rx_pkt = '0;
  logic tx_valid, rx_port_locked, purge_node;
  logic [PW-1:0] tx_pkt;
  logic [1:0] rx_port_sel;

  always #4 clk = ~clk;

  ring_roster_node #(.NPORTS(NP)) dut_i (
    .clk(clk), .rst(rst), .my_id(my_id), .roster_start(roster_start),
    .rx_valid(rx_valid), .rx_pkt(rx_pkt), .rx_accept(rx_accept),
    .tx_valid(tx_valid), .tx_pkt(tx_pkt), .rx_port_sel(rx_port_sel),
    .rx_port_locked(rx_port_locked), .port_wrap(port_wrap), .purge_node(purge_node)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int mc [256];
  bit m_lock, m_purge;
  int m_sel;
  bit [NP-1:0] m_pw;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_clear();
    foreach (mc[i]) mc[i] = 0;
    m_lock = 0; m_pw = '0; m_purge = 1;
  endtask

  task automatic model(input logic [PW-1:0] p, input int port, output bit fwd, output logic [PW-1:0] o);
    int w, l, c, s, ci;
    bit wr, drop;
    w = p[24]; l = p[23:16]; c = p[15:8]; s = p[7:0];
    ci = (c == 255) ? 255 : c + 1;
    fwd = 0; o = '0; wr = (ID < l); drop = 0;
    if (s == ID) begin
      if (ci > mc[s]) begin mc[s] = ci; m_sel = port; m_lock = 1; end
    end else begin
      if (wr) begin
        if (w == 1) drop = 1; else m_pw[port] = 1;
      end
      if (!drop && ci > mc[s]) begin
        mc[s] = ci; fwd = 1;
        o = {(w == 1) || wr, 8'(ID), 8'(ci), 8'(s)};
      end
    end
    if (s < ID) m_purge = 0;
  endtask

  task automatic do_start();
    @(negedge clk) roster_start = 1;
    @(negedge clk) roster_start = 0;
    m_clear();
    chk("R2 tx_valid", tx_valid, 1);
    chk("R2 tx_pkt", int'(tx_pkt), int'({1'b0, 8'(ID), 8'd0, 8'(ID)}));
    chk("R2 locked", rx_port_locked, 0);
    chk("R2 port_wrap", port_wrap, 0);
    chk("R2 purge", purge_node, 1);
  endtask

  task automatic send_one(input int port, input logic [PW-1:0] p);
    bit f;
    logic [PW-1:0] o;
    @(negedge clk);
    rx_pkt[port*PW +: PW] = p;
    rx_valid[port] = 1;
    model(p, port, f, o);
    @(negedge clk) rx_valid = '0;
    @(negedge clk);
    if (p[7:0] == 8'(ID)) chk("R4 own not forwarded", tx_valid, 0);
    else chk("R7/R6 forward decision", tx_valid, f);
    if (f && tx_valid) chk("R3 forwarded fields", int'(tx_pkt), int'(o));
    chk("R5 locked", rx_port_locked, m_lock);
    if (m_lock) chk("R5 port select", rx_port_sel, m_sel);
    chk("R6 port_wrap", port_wrap, m_pw);
    chk("R8 purge", purge_node, m_purge);
  endtask

  initial begin
    logic [PW-1:0] pk [NP];
    logic [PW-1:0] exp_o [NP];
    bit exp_f [NP];
    int order [NP];
    int cnts [4] = '{0, 3, 7, 255};
    int ltxs [3] = '{3, 5, 9};
    m_clear();
    m_purge = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 locked", rx_port_locked, 0);
    chk("R1 purge", purge_node, 0);
    chk("R1 port_wrap", port_wrap, 0);
    chk("R1 rx_accept", rx_accept, 0);

    // sweep over origins, counts, last-transmitter and wrap
    for (int org = 8; org >= 1; org--) begin
      do_start();
      for (int ci = 0; ci < 4; ci++)
        for (int li = 0; li < 3; li++)
          for (int w = 0; w < 2; w++)
            send_one((ci * 6 + li * 2 + w) % NP,
                     {w[0], 8'(ltxs[li]), 8'(cnts[ci]), 8'(org)});
    end

    // R9 / R11: four ports at once, ports 1 and 2 share an origin
    do_start();
    pk[0] = {1'b0, 8'd3, 8'd1, 8'd7};
    pk[1] = {1'b0, 8'd2, 8'd4, 8'd9};
    pk[2] = {1'b0, 8'd2, 8'd4, 8'd9};
    pk[3] = {1'b0, 8'd4, 8'd6, 8'(ID)};
    @(negedge clk);
    for (int p = 0; p < NP; p++) rx_pkt[p*PW +: PW] = pk[p];
    rx_valid = '1;
    for (int p = 0; p < NP; p++) model(pk[p], p, exp_f[p], exp_o[p]);
    for (int c = 0; c < NP + 2; c++) begin
      if (c > 0 && c <= NP) rx_valid[c-1] = 0;
      #1;
      if (c < NP) chk("R9 accept order", rx_accept, 1 << c);
      if (c >= 2) begin
        order[c-2] = c - 2;
        chk("R11/R9 forward sequence", tx_valid, exp_f[c-2]);
        if (exp_f[c-2]) chk("R3 forwarded fields", int'(tx_pkt), int'(exp_o[c-2]));
      end
      @(negedge clk);
    end
    chk("R5 select after burst", rx_port_sel, 3);
    chk("R11 second copy dropped", exp_f[2], 0);

    // R10: start while a packet is in flight
    @(negedge clk);
    rx_pkt[0 +: PW] = {1'b0, 8'd2, 8'd50, 8'd6};
    rx_valid[0] = 1;
    @(negedge clk);
    rx_valid = '0;
    roster_start = 1;
    #1 chk("R10 no accept during start", rx_accept, 0);
    @(negedge clk) roster_start = 0;
    chk("R10 originated packet", int'(tx_pkt), int'({1'b0, 8'(ID), 8'd0, 8'(ID)}));
    @(negedge clk);
    chk("R10 in-flight dropped", tx_valid, 0);
    m_clear();
    send_one(2, {1'b0, 8'd2, 8'd50, 8'd6});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule